// File: doc/BRIEF.md
# Protection Transform Unit with OR-Composed Banking

This block sits on a cartridge's CPU-facing byte bus and provides two protection features. The first is a pair of registers: a command and a data byte. Any read inside the device window returns a bit transform of the data byte, and the command picks which transform applies. The second is a bank register. For CPU addresses in the lowest megabyte, this register forms the ROM address by a bitwise OR of the bank offset with the CPU address. It does not add the offset.

The command register is held as an enumerated mode. The four modes, named in command order, are `XF_SHL`, `XF_SHR`, `XF_NIBSWAP` and `XF_BITREV`. A command write moves the unit from any mode to the mode given by the low two bits of the written byte. Reset places it in `XF_SHL`. No other transitions exist. The bank register changes only on an accepted bank write. A rejected write leaves it in its previous value.

Registers update on the rising clock edge that samples a write strobe. The read data bus and the ROM address are combinational functions of the registers and the current bus address.

Top module: `prot_or_bank`

## Requirements
- R1: A byte write (`bus_wr`=1) to an address in 0x600000–0x6FFFFF with address bit 1 clear stores `bus_wdata` in the data register. The stored value is visible from the clock edge that samples the write.
- R2: A byte write in 0x600000–0x6FFFFF with address bit 1 set loads the command from `bus_wdata[1:0]`. Bits 7:2 are ignored. Writes outside 0x600000–0x7FFFFF change neither the command nor the data register.
- R3: While `bus_rd`=1 in 0x600000–0x7FFFFF, `rd_data` returns the data register transformed by the command:
  - command 0: shifted left by one, truncated to 8 bits
  - command 1: shifted right by one
  - command 2: the two nibbles swapped
  - command 3: all eight bits reversed
- R4: When `bus_rd` is 0, or the address lies outside 0x600000–0x7FFFFF, `rd_data` is 0.
- R5: A byte write in 0x700000–0x7FFFFF sets the bank offset to `bus_wdata` shifted left by 15. This happens only when that offset plus 0x10000 is below `ROM_BYTES`.
- R6: A bank write whose offset plus 0x10000 is at least `ROM_BYTES` is rejected, and the previous bank offset is kept.
- R7: For `bus_addr` below 0x100000, `rom_addr` equals the bank offset ORed with `bus_addr`.
- R8: For `bus_addr` at or above 0x100000, `rom_addr` equals `bus_addr` unchanged.
- R9: Reset (`rst_n`=0) clears the bank offset, the data register and the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | CPU byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Transformed read data (0 when not selected) |
| rom_addr | output | 24 | Translated ROM byte address |

## Verification
Each register write takes effect at the one clock edge that samples its strobe. From that edge on, `rd_data` and `rom_addr` follow combinationally, with zero further cycles of delay. The bench drives every stimulus at a falling edge and lets one rising edge pass. It then samples at the next falling edge, where both the register update and the combinational output are settled. Checks of translation and read transforms need no edge at all. They change the address or read strobe at a falling edge and sample a short delay later.

// File: rtl/prot_or_bank_pkg.sv
package prot_or_bank_pkg;
    typedef enum logic [1:0] {
        XF_SHL     = 2'd0,
        XF_SHR     = 2'd1,
        XF_NIBSWAP = 2'd2,
        XF_BITREV  = 2'd3
    } xform_e;
endpackage

// File: rtl/ob_decode.sv
module ob_decode #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              rd_hit,
    output logic              wr_data,
    output logic              wr_cmd,
    output logic              wr_bank,
    output logic              low_mb
);
    localparam logic [2:0] WIN_TAG = 3'b011;
    logic in_win;
    logic bank_half;

    always_comb begin
        in_win    = (addr[ADDR_W-1 -: 3] == WIN_TAG);
        bank_half = addr[ADDR_W-4];
        rd_hit    = rd && in_win;
        wr_data   = wr && in_win && !bank_half && !addr[1];
        wr_cmd    = wr && in_win && !bank_half &&  addr[1];
        wr_bank   = wr && in_win &&  bank_half;
        low_mb    = (addr[ADDR_W-1 -: 4] == 4'd0);
    end
endmodule

// File: rtl/ob_alu.sv
module ob_alu
    import prot_or_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_cmd,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_value,
    output xform_e            mode_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int HALF = DATA_W / 2;
    xform_e            mode_d;
    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] xf;

    // mode register: any mode -> mode named by wdata[1:0] on a command write
    always_comb begin
        mode_d = mode_q;
        if (wr_cmd) mode_d = xform_e'(wdata[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= XF_SHL;
            data_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (wr_data) data_q <= wdata;
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev[i] = data_q[DATA_W-1-i];
    end

    always_comb begin
        unique case (mode_q)
            XF_SHL:     xf = data_q << 1;
            XF_SHR:     xf = data_q >> 1;
            XF_NIBSWAP: xf = {data_q[HALF-1:0], data_q[DATA_W-1:HALF]};
            XF_BITREV:  xf = rev;
        endcase
        rd_value = rd_hit ? xf : '0;
    end
endmodule

// File: rtl/ob_bank.sv
module ob_bank #(
    parameter int          ADDR_W     = 24,
    parameter int          DATA_W     = 8,
    parameter int          BANK_SHIFT = 15,
    parameter logic [31:0] GUARD      = 32'h0001_0000,
    parameter logic [31:0] ROM_BYTES  = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_bank,
    input  logic              low_mb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] bank_q,
    output logic [ADDR_W-1:0] rom_addr
);
    logic [31:0] cand;
    logic        fits;

    always_comb begin
        cand = 32'(wdata) << BANK_SHIFT;
        fits = (cand + GUARD) < ROM_BYTES;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               bank_q <= '0;
        else if (wr_bank && fits) bank_q <= cand[ADDR_W-1:0];
    end

    always_comb rom_addr = low_mb ? (bank_q | addr) : addr;
endmodule

// File: rtl/prot_or_bank.sv
module prot_or_bank
    import prot_or_bank_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          DATA_W     = 8,
    parameter int          BANK_SHIFT = 15,
    parameter logic [31:0] ROM_BYTES  = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr
);
    logic              rd_hit, wr_data, wr_cmd, wr_bank, low_mb;
    xform_e            mode_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] bank_q;

    ob_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .rd_hit(rd_hit), .wr_data(wr_data), .wr_cmd(wr_cmd),
        .wr_bank(wr_bank), .low_mb(low_mb)
    );

    ob_alu #(.DATA_W(DATA_W)) u_alu (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cmd(wr_cmd),
        .rd_hit(rd_hit), .wdata(bus_wdata), .rd_value(rd_data),
        .mode_q(mode_q), .data_q(data_q)
    );

    ob_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_SHIFT(BANK_SHIFT),
        .ROM_BYTES(ROM_BYTES)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .low_mb(low_mb),
        .wdata(bus_wdata), .addr(bus_addr), .bank_q(bank_q),
        .rom_addr(rom_addr)
    );
endmodule

// File: rtl/prot_or_bank_chk.sv
module prot_or_bank_chk #(
    parameter int          ADDR_W     = 24,
    parameter int          DATA_W     = 8,
    parameter int          BANK_SHIFT = 15,
    parameter logic [31:0] ROM_BYTES  = 32'h0020_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [DATA_W-1:0] data_q,
    input logic [1:0]        mode_q,
    input logic [ADDR_W-1:0] bank_q
);
    logic in_win, lo_half, hi_half, low_mb, fits;
    always_comb begin
        in_win  = bus_addr[ADDR_W-1 -: 3] == 3'b011;
        lo_half = in_win && !bus_addr[ADDR_W-4];
        hi_half = in_win &&  bus_addr[ADDR_W-4];
        low_mb  = bus_addr < (ADDR_W'(1) << 20);
        fits    = ((32'(bus_wdata) << BANK_SHIFT) + 32'h1_0000) < ROM_BYTES;
    end

    assert_data_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && lo_half && !bus_addr[1] |=> data_q == $past(bus_wdata));

    assert_cmd_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && lo_half && bus_addr[1] |=> mode_q == $past(bus_wdata[1:0]));

    assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_win) |=> $stable(data_q) && $stable(mode_q) && $stable(bank_q));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && in_win) |-> rd_data == '0);

    assert_bank_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hi_half && fits |=> 32'(bank_q) == (32'($past(bus_wdata)) << BANK_SHIFT));

    assert_bank_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hi_half && !fits |=> $stable(bank_q));

    assert_or_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_mb |-> rom_addr == (bank_q | bus_addr));

    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !low_mb |-> rom_addr == bus_addr);
endmodule

bind prot_or_bank prot_or_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_SHIFT(BANK_SHIFT), .ROM_BYTES(ROM_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
    .rom_addr(rom_addr), .data_q(data_q), .mode_q(mode_q), .bank_q(bank_q)
);

// File: tb/tb_prot_or_bank.sv
module tb_prot_or_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  rd_data;
    logic [23:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_or_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
        .rom_addr(rom_addr)
    );

    function automatic logic [7:0] model_xf(input logic [1:0] c, input logic [7:0] d);
        logic [7:0] r;
        case (c)
            2'd0: r = {d[6:0], 1'b0};
            2'd1: r = {1'b0, d[7:1]};
            2'd2: r = {d[3:0], d[7:4]};
            default: for (int i = 0; i < 8; i++) r[i] = d[7-i];
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 24'h0;
    endtask

    task automatic rd_byte(input logic [23:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = rd_data;
        bus_rd = 1'b0;
    endtask

    task automatic map_of(input logic [23:0] a, output logic [23:0] r);
        @(negedge clk);
        bus_addr = a;
        #1 r = rom_addr;
    endtask

    task automatic t_reset;
        logic [7:0]  v;
        logic [23:0] m;
        rd_byte(24'h600000, v);
        check("R9 data/cmd reset", v, 8'h00);
        map_of(24'h012345, m);
        check("R9 bank reset", m, 24'h012345);
    endtask

    task automatic t_transforms;
        logic [7:0] v;
        wr_byte(24'h600000, 8'hB4);
        for (int c = 0; c < 4; c++) begin
            wr_byte(24'h600002, 8'(c));
            rd_byte(24'h600001, v);
            check($sformatf("R3 cmd%0d", c), v, model_xf(2'(c), 8'hB4));
        end
        wr_byte(24'h600000, 8'hC3);
        wr_byte(24'h600002, 8'h00);
        rd_byte(24'h7ABCDE, v);
        check("R3 shl truncation, read in bank half", v, 8'h86);
        check("R1 data store", model_xf(2'd2, 8'hC3), 8'h3C);
        wr_byte(24'h600002, 8'h02);
        rd_byte(24'h600000, v);
        check("R1 data readback via swap", v, 8'h3C);
    endtask

    task automatic t_cmd_and_ignore;
        logic [7:0] v;
        wr_byte(24'h600000, 8'h81);
        wr_byte(24'h6FFFFE, 8'hFD);
        rd_byte(24'h600000, v);
        check("R2 upper cmd bits ignored", v, model_xf(2'd1, 8'h81));
        wr_byte(24'h500000, 8'h55);
        wr_byte(24'h800002, 8'h03);
        rd_byte(24'h600000, v);
        check("R2 outside writes ignored", v, model_xf(2'd1, 8'h81));
    endtask

    task automatic t_no_read;
        logic [7:0] v;
        rd_byte(24'h5FFFFF, v);
        check("R4 outside window", v, 8'h00);
        @(negedge clk);
        bus_addr = 24'h600000; bus_rd = 1'b0;
        #1 check("R4 no strobe", rd_data, 8'h00);
    endtask

    task automatic t_bank;
        logic [23:0] m;
        wr_byte(24'h700001, 8'h05);
        map_of(24'h012345, m);
        check("R7 OR translation", m, 24'h03A345);
        map_of(24'h0FFFFF, m);
        check("R7 OR overlapping bits", m, 24'h0FFFFF);
        map_of(24'h150000, m);
        check("R8 passthrough", m, 24'h150000);
        wr_byte(24'h7FFFFF, 8'h3D);
        map_of(24'h000100, m);
        check("R5 largest accepted bank", m, 24'h1E8100);
        wr_byte(24'h700000, 8'h3E);
        map_of(24'h000100, m);
        check("R6 boundary reject keeps bank", m, 24'h1E8100);
        wr_byte(24'h700000, 8'hFF);
        map_of(24'h000000, m);
        check("R6 large reject keeps bank", m, 24'h1E8000);
        map_of(24'h600000, m);
        check("R8 device window passthrough", m, 24'h600000);
    endtask

    task automatic t_rereset;
        logic [23:0] m;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        map_of(24'h000010, m);
        check("R9 bank cleared by reset", m, 24'h000010);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transforms();
        t_cmd_and_ignore();
        t_no_read();
        t_bank();
        t_rereset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule